// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a free-running input clock into the timing strobes a UART needs. It divides the clock by a 16-bit integer divisor, held in two byte-wide latches, plus a fraction of k/16 where k is a 4-bit prescale value. The result is a single-cycle oversample strobe. A second strobe marks every 16th, 8th or 4th oversample strobe, as a two-bit sampling-rate field selects. That second strobe is the per-bit timing for the serial data path.

The fraction comes from a 4-bit phase accumulator. Each time a divide period ends, the prescale value is added to it. A carry out of the accumulator lengthens the following period by one input clock. Over any 16 periods exactly k of them are one clock longer, so the average divisor is N + k/16. Writing either byte of the divisor restarts the divide counter, the phase accumulator and the oversample count, so the new rate begins from a known phase. With a divisor of zero both strobes stay low.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is asserted, and after reset until a divisor byte is written, both latches hold zero and neither `ovsTick` nor `bitTick` is ever high.
- R2: A cycle with `wrLo` high loads `wrData` into bits 7:0 of the divisor. A cycle with `wrHi` high loads `wrData` into bits 15:8. The divisor N is the concatenation {high byte, low byte}.
- R3: With `prescale` = 0, the m-th `ovsTick` after a restart edge is high in the cycle that ends m*N clock edges after that restart edge. The strobes are therefore exactly N cycles apart, and N = 1 keeps `ovsTick` high continuously.
- R4: With prescale value k, the m-th `ovsTick` after a restart edge is high in the cycle that ends m*N + floor((m-1)*k/16) edges after that restart edge. The first period after a restart is never lengthened.
- R5: `sampSel` encoding: 2'b00 selects 16 samples per bit, 2'b01 selects 8, and 2'b10 or 2'b11 select 4. `bitTick` is high together with the r-th, 2r-th, 3r-th ... `ovsTick` after a restart, where r is the selected ratio, and is low at all other times.
- R6: A write to either divisor byte, even when it leaves the value unchanged, restarts the divide counter, the phase accumulator and the oversample count at that clock edge. The next `ovsTick` then appears only after a full N-cycle period.
- R7: With a divisor of zero, `ovsTick` and `bitTick` stay low.
- R8: With N = 1, k = 0 and 4x sampling, `bitTick` is high once every 4 clock cycles. An 80 MHz input clock therefore gives 20 Mbit/s.
- R9: With a nonzero divisor, every gap between consecutive `ovsTick` strobes, with no restart in between, is exactly N or N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 8 | Byte written into a divisor latch |
| wrLo | input | 1 | Load `wrData` into the low divisor byte and restart |
| wrHi | input | 1 | Load `wrData` into the high divisor byte and restart |
| prescale | input | 4 | Fractional part k of the divisor, in sixteenths |
| sampSel | input | 2 | Samples per bit: 00=16, 01=8, 10/11=4 |
| ovsTick | output | 1 | Oversample strobe, one cycle wide |
| bitTick | output | 1 | Per-bit strobe, coincides with every r-th `ovsTick` |

## Verification
The bench builds the block with its default parameters: 8-bit divisor bytes, giving a 16-bit divisor, and a 4-bit fraction. It sweeps every one of the 16 prescale values against small divisors of 1 to 4, and cycles all four sampling codes through that sweep. For each strobe it predicts the exact cycle from the closed form m*N + floor((m-1)*k/16). Small divisors keep every fraction pattern and several per-bit strobes within a few hundred cycles per setting. A divisor of 257 exercises the high byte, a zero divisor checks that the strobes stay silent, and a low-byte-only rewrite in mid-period checks the restart.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int SAMP_CNT_W = 4;

  typedef enum logic [1:0] {
    SAMP_X16  = 2'b00,
    SAMP_X8   = 2'b01,
    SAMP_X4   = 2'b10,
    SAMP_X4B  = 2'b11
  } sampSel_e;

  typedef struct packed {
    logic restart;
    logic run;
  } ctrlStrobes_t;

  function automatic logic [SAMP_CNT_W-1:0] lastSample(input logic [1:0] sel);
    case (sampSel_e'(sel))
      SAMP_X16: lastSample = SAMP_CNT_W'(15);
      SAMP_X8:  lastSample = SAMP_CNT_W'(7);
      default:  lastSample = SAMP_CNT_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [1:0]        sampSel,
  input  logic              ovsTick,
  output logic [DIV_W-1:0]  divisor,
  output ctrlStrobes_t      strb,
  output logic              bitTick
);

  logic [1:0]            laneWr;
  logic [BYTE_W-1:0]     lane [2];
  logic [SAMP_CNT_W-1:0] sampCnt;
  logic [SAMP_CNT_W-1:0] sampLast;

  assign laneWr = {wrHi, wrLo};

  for (genvar i = 0; i < 2; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          lane[i] <= '0;
      else if (laneWr[i]) lane[i] <= wrData;
    end
    assign divisor[i*BYTE_W +: BYTE_W] = lane[i];
  end

  assign strb.restart = |laneWr;
  assign strb.run     = |divisor;
  assign sampLast     = lastSample(sampSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sampCnt <= '0;
    else if (strb.restart) sampCnt <= '0;
    else if (ovsTick)      sampCnt <= (sampCnt >= sampLast) ? '0 : sampCnt + 1'b1;
  end

  assign bitTick = ovsTick && (sampCnt >= sampLast);

endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] prescale,
  input  ctrlStrobes_t      strb,
  output logic              ovsTick
);

  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  lastIdx;
  logic [FRAC_W-1:0] phase;
  logic              stretch;
  logic [FRAC_W:0]   phaseSum;
  logic              periodEnd;

  // stretch holds the carry from the previous period's phase update
  assign lastIdx   = divisor - 1'b1 + DIV_W'(stretch);
  assign periodEnd = strb.run && (cnt == lastIdx);
  assign phaseSum  = {1'b0, phase} + {1'b0, prescale};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      phase   <= '0;
      stretch <= 1'b0;
    end else if (strb.restart || !strb.run) begin
      cnt     <= '0;
      phase   <= '0;
      stretch <= 1'b0;
    end else if (periodEnd) begin
      cnt     <= '0;
      phase   <= phaseSum[FRAC_W-1:0];
      stretch <= phaseSum[FRAC_W];
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  assign ovsTick = periodEnd;

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [FRAC_W-1:0] prescale,
  input  logic [1:0]        sampSel,
  output logic              ovsTick,
  output logic              bitTick
);

  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0] divisor;
  ctrlStrobes_t     strb;

  baud_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (wrData),
    .wrLo    (wrLo),
    .wrHi    (wrHi),
    .sampSel (sampSel),
    .ovsTick (ovsTick),
    .divisor (divisor),
    .strb    (strb),
    .bitTick (bitTick)
  );

  baud_datapath #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .divisor  (divisor),
    .prescale (prescale),
    .strb     (strb),
    .ovsTick  (ovsTick)
  );

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrLo,
  input logic             wrHi,
  input logic [DIV_W-1:0] divisor,
  input logic             ovsTick,
  input logic             bitTick
);

  logic [DIV_W:0] since;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       since <= '0;
    else if (wrLo || wrHi || ovsTick) since <= (DIV_W+1)'(1);
    else if (since != '1)            since <= since + 1'b1;
  end

  // R1: quiet while in reset
  always @(negedge clk) begin
    if (!rstN) assert_reset_quiet_R1: assert (!ovsTick && !bitTick);
  end

  assert_zero_div_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> (!ovsTick && !bitTick));

  assert_restart_full_period_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo || wrHi) |=> (!ovsTick || divisor == DIV_W'(1)));

  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && divisor != '0 && since != '0) |->
      (since == {1'b0, divisor} || since == {1'b0, divisor} + 1'b1));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrLo    (wrLo),
  .wrHi    (wrHi),
  .divisor (divisor),
  .ovsTick (ovsTick),
  .bitTick (bitTick)
);

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrLo = 1'b0;
  logic       wrHi = 1'b0;
  logic [3:0] prescale = '0;
  logic [1:0] sampSel = '0;
  logic       ovsTick;
  logic       bitTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_frac_gen dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrLo(wrLo), .wrHi(wrHi),
    .prescale(prescale), .sampSel(sampSel), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the last write edge
  task automatic writeDiv(input int n, input bit loOnly);
    wrData = n[7:0]; wrLo = 1'b1;
    @(posedge clk); @(negedge clk);
    wrLo = 1'b0;
    if (!loOnly) begin
      wrData = n[15:8]; wrHi = 1'b1;
      @(posedge clk); @(negedge clk);
      wrHi = 1'b0;
    end
  endtask

  task automatic runCfg(input int n, input int k, input int sel, input int nTicks,
                        input bit loOnly, input string ovsReq, input string bitReq);
    int ratio;
    int m;
    int nextD;
    int limit;
    bit expOvs;
    bit expBit;
    ratio = (sel == 0) ? 16 : (sel == 1) ? 8 : 4;
    prescale = k[3:0];
    sampSel  = sel[1:0];
    writeDiv(n, loOnly);
    m = 1;
    nextD = n;
    limit = nTicks * (n + 1) + 2;
    for (int c = 0; c < limit; c++) begin
      expOvs = (c + 1 == nextD);
      expBit = expOvs && (m % ratio == 0);
      check(ovsTick, expOvs, ovsReq, $sformatf("ovsTick n=%0d k=%0d c=%0d", n, k, c));
      check(bitTick, expBit, bitReq, $sformatf("bitTick n=%0d sel=%0d c=%0d", n, sel, c));
      if (expOvs) begin
        m++;
        nextD = m * n + ((m - 1) * k) / 16;
      end
      if (m > nTicks) break;
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ovsTick, 1'b0, "R1", "ovsTick in reset");
    check(bitTick, 1'b0, "R1", "bitTick in reset");
    rstN = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check(ovsTick, 1'b0, "R1", "ovsTick after reset, no write");
      check(bitTick, 1'b0, "R1", "bitTick after reset, no write");
    end

    // R3/R4/R5: sweep every prescale value over small divisors, rotating sampling codes
    for (int n = 1; n <= 4; n++) begin
      for (int k = 0; k < 16; k++) begin
        int sel;
        int ratio;
        sel = (k + n) % 4;
        ratio = (sel == 0) ? 16 : (sel == 1) ? 8 : 4;
        runCfg(n, k, sel, 2 * ratio + 1, 1'b0, (k == 0) ? "R3" : "R4", "R5");
      end
    end

    // R5: every sampling code at one fractional setting
    for (int sel = 0; sel < 4; sel++) runCfg(3, 5, sel, 33, 1'b0, "R4", "R5");

    // R8: fastest 4x setting
    runCfg(1, 0, 2, 24, 1'b0, "R8", "R8");

    // R2: divisor needing the high byte
    runCfg(257, 5, 2, 9, 1'b0, "R2", "R2");
    runCfg(2 * 256 + 3, 0, 1, 9, 1'b0, "R2", "R2");

    // R6: interrupt a running divider mid-period with a low-byte-only rewrite
    runCfg(6, 3, 1, 5, 1'b0, "R6", "R6");
    repeat (3) @(negedge clk);
    runCfg(6, 3, 1, 17, 1'b1, "R6", "R6");

    // R7: zero divisor stays silent
    prescale = 4'd9;
    writeDiv(0, 1'b0);
    for (int c = 0; c < 100; c++) begin
      check(ovsTick, 1'b0, "R7", "ovsTick with zero divisor");
      check(bitTick, 1'b0, "R7", "bitTick with zero divisor");
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule